// File: doc/BRIEF.md
# Dual-Mode Output-Compare PWM Generator

This block drives one PWM pin from a pair of compare values: a duty value and a secondary value. In edge-aligned mode the block has its own counter, paced by a prescaled clock tick. The secondary value sets the period and the duty value sets how long the pin stays high after each wrap. In center-aligned mode an outside timer supplies both its running count and its period limit. The pin rises when that count meets the duty value and falls when it meets the secondary value.

Software may write either compare value at any cycle. Each write lands in a pending copy. The working copy that the comparators use is refreshed only when a period completes, so a change never cuts a pulse short or stretches it. Both modes have fixed saturation rules that give a solid 0% or 100% output.

Top module: `oc_pwm_gen`

## Requirements
- R1: A synchronous active-high reset clears the pending and working compare values, the edge counter, the prescaler and the center flag, so the pin reads low.
- R2: In edge-aligned mode (mode = 0) the counter runs from 0 up to the working secondary value S and then wraps to 0, one step per prescaled enable. The pin is high while the count is below the working duty value D, so each period is S+1 enables long and high for D of them.
- R3: The prescaler select picks 1 enable per 1, 8, 64 or 256 ticks for codes 0, 1, 2 and 3 respectively.
- R4: A write to either compare value does not change the output within the current period. It takes effect from the next period boundary.
- R5: In edge-aligned mode a working duty value of 0 keeps the pin low, including when both values are 0.
- R6: In edge-aligned mode a working duty value greater than the working secondary value keeps the pin high.
- R7: In center-aligned mode (mode = 1), on each tick the pin goes high when the timer count equals the duty value and goes low when it equals the secondary value.
- R8: In center-aligned mode the working values reload on a tick where the timer count equals the timer period.
- R9: In center-aligned mode a working secondary value greater than the timer period keeps the pin high.
- R10: In center-aligned mode, when the count matches the duty and secondary values in the same tick, the fall wins. With all three values at 0 the pin stays low.
- R11: A write in the same cycle as a period boundary loads the working copy with the pending value as it stood before that write. The new value takes effect one period later.
- R12: With tick low, no counter or flag advances and no reload happens, so the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle enable |
| presc_sel | input | 2 | Prescaler code: 0=1:1, 1=1:8, 2=1:64, 3=1:256 |
| mode | input | 1 | 0 = edge-aligned, 1 = center-aligned |
| wr_duty | input | 1 | Write strobe for the pending duty value |
| wr_sec | input | 1 | Write strobe for the pending secondary value |
| wr_data | input | 16 | Data for either write |
| tmr_count | input | 16 | Running count of the outside sync timer |
| tmr_period | input | 16 | Period limit of the outside sync timer |
| pwm_out | output | 1 | PWM pin |

## Verification
The bench places writes at exact points in the period: one three counts after a rise, and one in the very cycle of the wrap. A design that loaded writes at once would lengthen the current pulse. A design that passed write data straight to the working copy would show the new width one period early. The saturation corners come next: duty 0, duty above period, secondary above the timer period, and all zero. A wrong comparison direction or the wrong set/clear priority shows up there as a stray pulse or a dropped one. Each prescaler ratio is measured as the spacing between rising edges, and a run with tick low with a pending write proves that nothing moves without tick.

// File: rtl/oc_pwm_pkg.sv
package oc_pwm_pkg;

    localparam int PWM_W = 16;
    localparam int PS_W  = 8;

    typedef enum logic {
        MODE_EDGE   = 1'b0,
        MODE_CENTER = 1'b1
    } pwm_mode_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV8   = 2'd1,
        PS_DIV64  = 2'd2,
        PS_DIV256 = 2'd3
    } ps_sel_e;

    typedef struct packed {
        logic [PWM_W-1:0] duty;
        logic [PWM_W-1:0] sec;
    } cmp_pair_t;

    function automatic logic [PS_W-1:0] presc_limit(input ps_sel_e sel);
        case (sel)
            PS_DIV1:  presc_limit = PS_W'(0);
            PS_DIV8:  presc_limit = PS_W'(7);
            PS_DIV64: presc_limit = PS_W'(63);
            default:  presc_limit = PS_W'(255);
        endcase
    endfunction

endpackage

// File: rtl/oc_pwm_prescaler.sv
module oc_pwm_prescaler
    import oc_pwm_pkg::*;
#(
    parameter int CW = PS_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  ps_sel_e sel,
    output logic    cnt_en
);
    logic [CW-1:0] div_q;
    logic [CW-1:0] limit;

    assign limit  = CW'(presc_limit(sel));
    assign cnt_en = tick && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= cnt_en ? '0 : div_q + 1'b1;
        end
    end

    assert_div_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(div_q));
endmodule

// File: rtl/oc_pwm_shadow.sv
module oc_pwm_shadow
    import oc_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_duty,
    input  logic             wr_sec,
    input  logic [PWM_W-1:0] wr_data,
    input  logic             load,
    output cmp_pair_t        work
);
    cmp_pair_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            work <= '0;
        end else begin
            if (wr_duty) pend.duty <= wr_data;
            if (wr_sec)  pend.sec  <= wr_data;
            if (load)    work      <= pend;
        end
    end

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(work));
endmodule

// File: rtl/oc_pwm_edge_core.sv
module oc_pwm_edge_core
    import oc_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             edge_mode,
    input  cmp_pair_t        act,
    output logic [PWM_W-1:0] ecnt,
    output logic             level,
    output logic             wrap
);
    assign wrap  = edge_mode && cnt_en && (ecnt >= act.sec);
    assign level = (ecnt < act.duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt <= '0;
        end else if (!edge_mode) begin
            ecnt <= '0;
        end else if (cnt_en) begin
            ecnt <= wrap ? '0 : ecnt + 1'b1;
        end
    end
endmodule

// File: rtl/oc_pwm_center_core.sv
module oc_pwm_center_core
    import oc_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PWM_W-1:0] tmr_count,
    input  logic [PWM_W-1:0] tmr_period,
    input  cmp_pair_t        act,
    output logic             level,
    output logic             wrap
);
    logic flag_q;

    assign wrap  = tick && (tmr_count == tmr_period);
    assign level = (act.sec > tmr_period) || flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (tick) begin
            if (tmr_count == act.sec)       flag_q <= 1'b0;
            else if (tmr_count == act.duty) flag_q <= 1'b1;
        end
    end

    assert_fall_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && tmr_count == act.sec && tmr_count == act.duty) |=> !flag_q);
endmodule

// File: rtl/oc_pwm_gen.sv
module oc_pwm_gen
    import oc_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [1:0]       presc_sel,
    input  logic             mode,
    input  logic             wr_duty,
    input  logic             wr_sec,
    input  logic [PWM_W-1:0] wr_data,
    input  logic [PWM_W-1:0] tmr_count,
    input  logic [PWM_W-1:0] tmr_period,
    output logic             pwm_out
);
    pwm_mode_e        mode_e;
    ps_sel_e          sel_e;
    logic             cnt_en;
    logic             load;
    cmp_pair_t        act;
    logic [PWM_W-1:0] ecnt;
    logic             e_level, e_wrap;
    logic             c_level, c_wrap;

    assign mode_e = pwm_mode_e'(mode);
    assign sel_e  = ps_sel_e'(presc_sel);

    oc_pwm_prescaler u_presc (
        .clk(clk), .rst(rst), .tick(tick), .sel(sel_e), .cnt_en(cnt_en)
    );

    oc_pwm_shadow u_shadow (
        .clk(clk), .rst(rst), .wr_duty(wr_duty), .wr_sec(wr_sec),
        .wr_data(wr_data), .load(load), .work(act)
    );

    oc_pwm_edge_core u_edge (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .edge_mode(mode_e == MODE_EDGE), .act(act),
        .ecnt(ecnt), .level(e_level), .wrap(e_wrap)
    );

    oc_pwm_center_core u_center (
        .clk(clk), .rst(rst), .tick(tick), .tmr_count(tmr_count),
        .tmr_period(tmr_period), .act(act), .level(c_level), .wrap(c_wrap)
    );

    assign load    = (mode_e == MODE_EDGE) ? e_wrap : c_wrap;
    assign pwm_out = (mode_e == MODE_EDGE) ? e_level : c_level;

    assert_ctr_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_EDGE) |-> (ecnt <= act.sec));
    assert_div1_every_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && sel_e == PS_DIV1) |-> cnt_en);
    assert_edge_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_EDGE && act.duty == '0) |-> !pwm_out);
    assert_edge_full_high_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_EDGE && act.duty > act.sec) |-> pwm_out);
    assert_center_all_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_CENTER && act.duty == '0 && act.sec == '0
         && tmr_period == '0 && tmr_count == '0) |=> !pwm_out);
endmodule

// File: tb/oc_pwm_gen_tb.sv
`timescale 1ns/1ps
module oc_pwm_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  presc_sel = 2'd0;
    logic        mode = 1'b0;
    logic        wr_duty = 1'b0;
    logic        wr_sec = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] tmr_count = '0;
    logic [15:0] tmr_period = '0;
    logic        pwm_out;

    int checks = 0;
    int fails = 0;
    int tc = 0;

    always #2 clk = ~clk;

    oc_pwm_gen u_dut (
        .clk(clk), .rst(rst), .tick(tick), .presc_sel(presc_sel), .mode(mode),
        .wr_duty(wr_duty), .wr_sec(wr_sec), .wr_data(wr_data),
        .tmr_count(tmr_count), .tmr_period(tmr_period), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_val(input bit sec, input logic [15:0] v);
        wr_duty = !sec; wr_sec = sec; wr_data = v;
        @(negedge clk);
        wr_duty = 1'b0; wr_sec = 1'b0;
    endtask

    task automatic edge_run(input int n, output int highs, output int spacing);
        int r1 = -1, r2 = -1;
        logic prev = pwm_out;
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            if (i > 0 && pwm_out && !prev) begin
                if (r1 < 0) r1 = i;
                else if (r2 < 0) r2 = i;
            end
            prev = pwm_out;
            @(negedge clk);
        end
        spacing = (r1 >= 0 && r2 >= 0) ? r2 - r1 : -1;
    endtask

    task automatic wait_rise();
        logic prev = pwm_out;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) return;
            prev = pwm_out;
        end
    endtask

    task automatic center_run(input int n, input int wstep, input logic [15:0] wval,
                              output int highs, output int rise_at,
                              output int fall1, output int fall2);
        logic prev = pwm_out;
        int last = tc;
        highs = 0; rise_at = -1; fall1 = -1; fall2 = -1;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            if (i > 0 && pwm_out && !prev && rise_at < 0) rise_at = last;
            if (i > 0 && !pwm_out && prev && i > wstep) begin
                if (fall1 < 0) fall1 = last;
                else if (fall2 < 0) fall2 = last;
            end
            prev = pwm_out;
            wr_sec = (i == wstep); wr_data = wval;
            tmr_count = 16'(tc); last = tc;
            tc = (tc >= int'(tmr_period)) ? 0 : tc + 1;
            @(negedge clk);
        end
        wr_sec = 1'b0;
    endtask

    task automatic t_reset();
        int h, sp;
        step(3);
        check(pwm_out == 1'b0, "R1 low in reset", pwm_out, 0);
        rst = 1'b0; tick = 1'b1;
        edge_run(10, h, sp);
        check(h == 0, "R1 low after reset", h, 0);
    endtask

    task automatic t_edge_basic();
        int h, sp;
        write_val(0, 16'd3); write_val(1, 16'd9);
        step(30);
        edge_run(40, h, sp);
        check(h == 12, "R2 high count", h, 12);
        check(sp == 10, "R2 period", sp, 10);
    endtask

    task automatic t_midperiod_write();
        int h;
        wait_rise();
        wr_duty = 1'b1; wr_data = 16'd8;
        @(negedge clk); wr_duty = 1'b0;
        step(2);
        check(pwm_out == 1'b0, "R4 old duty kept in period", pwm_out, 0);
        step(7);
        h = 0;
        for (int i = 0; i < 10; i++) begin if (pwm_out) h++; @(negedge clk); end
        check(h == 8, "R4 new duty next period", h, 8);
    endtask

    task automatic t_boundary_write();
        int h;
        wait_rise();
        step(9);
        wr_duty = 1'b1; wr_data = 16'd5;
        @(negedge clk); wr_duty = 1'b0;
        h = 0;
        for (int i = 0; i < 10; i++) begin if (pwm_out) h++; @(negedge clk); end
        check(h == 8, "R11 prior pending loaded", h, 8);
        h = 0;
        for (int i = 0; i < 10; i++) begin if (pwm_out) h++; @(negedge clk); end
        check(h == 5, "R11 write one period later", h, 5);
    endtask

    task automatic t_edge_sat();
        int h, sp;
        write_val(0, 16'd0); write_val(1, 16'd0);
        step(30);
        edge_run(40, h, sp);
        check(h == 0, "R5 both zero low", h, 0);
        write_val(1, 16'd9);
        step(30);
        edge_run(40, h, sp);
        check(h == 0, "R5 duty zero low", h, 0);
        write_val(0, 16'd12);
        step(30);
        edge_run(40, h, sp);
        check(h == 40, "R6 duty above period high", h, 40);
    endtask

    task automatic t_presc(input logic [1:0] sel, input int ratio);
        int h, sp;
        presc_sel = sel;
        write_val(0, 16'd1); write_val(1, 16'd1);
        step(12 * ratio + 20);
        edge_run(6 * ratio, h, sp);
        check(h == 3 * ratio, "R3 prescaled high count", h, 3 * ratio);
        check(sp == 2 * ratio, "R3 prescaled period", sp, 2 * ratio);
    endtask

    task automatic t_tick_gate();
        int h, sp, changes;
        logic hold;
        presc_sel = 2'd0;
        write_val(0, 16'd3); write_val(1, 16'd9);
        step(30);
        wait_rise();
        step(1);
        tick = 1'b0;
        hold = pwm_out;
        write_val(0, 16'd7);
        changes = 0;
        for (int i = 0; i < 50; i++) begin
            if (pwm_out != hold) changes++;
            @(negedge clk);
        end
        check(changes == 0, "R12 frozen without tick", changes, 0);
        check(hold == 1'b1, "R12 level held", hold, 1);
        tick = 1'b1;
        step(30);
        edge_run(40, h, sp);
        check(h == 28, "R4 pending applied after ticks resume", h, 28);
    endtask

    task automatic t_center();
        int h, r, f1, f2;
        mode = 1'b1; tmr_period = 16'd9; tc = 0; tmr_count = '0;
        write_val(0, 16'd2); write_val(1, 16'd6);
        center_run(20, -1, 16'd0, h, r, f1, f2);
        center_run(40, -1, 16'd0, h, r, f1, f2);
        check(h == 16, "R7 high count", h, 16);
        check(r == 2, "R7 rise at duty", r, 2);
        check(f1 == 6, "R7 fall at secondary", f1, 6);
        center_run(30, 3, 16'd8, h, r, f1, f2);
        check(f1 == 6, "R8 no reload mid period", f1, 6);
        check(f2 == 8, "R8 reload at timer wrap", f2, 8);
        write_val(1, 16'd12);
        center_run(20, -1, 16'd0, h, r, f1, f2);
        center_run(40, -1, 16'd0, h, r, f1, f2);
        check(h == 40, "R9 secondary above period high", h, 40);
        write_val(0, 16'd4); write_val(1, 16'd4);
        center_run(20, -1, 16'd0, h, r, f1, f2);
        center_run(40, -1, 16'd0, h, r, f1, f2);
        check(h == 0, "R10 equal match falls", h, 0);
        tmr_period = 16'd0; tc = 0;
        write_val(0, 16'd0); write_val(1, 16'd0);
        center_run(20, -1, 16'd0, h, r, f1, f2);
        center_run(40, -1, 16'd0, h, r, f1, f2);
        check(h == 0, "R10 all zero low", h, 0);
    endtask

    task automatic t_reset_again();
        mode = 1'b0;
        write_val(0, 16'd12); write_val(1, 16'd9);
        step(30);
        check(pwm_out == 1'b1, "R6 high before reset", pwm_out, 1);
        tick = 1'b0; rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(3);
        check(pwm_out == 1'b0, "R1 reset clears working", pwm_out, 0);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_edge_basic();
        t_midperiod_write();
        t_boundary_write();
        t_edge_sat();
        t_presc(2'd1, 8);
        t_presc(2'd2, 64);
        t_presc(2'd3, 256);
        t_tick_gate();
        t_center();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule